// File: doc/BRIEF.md
# Triggered Snapshot Capture Buffer

This block records a short burst of an incoming sample stream into on-chip RAM once a trigger has fired, so that slower control logic can read the burst back afterwards. Each stored entry packs an unsigned power word next to a one-bit flag that says whether the producer marked that sample as valid. Because the write enable can simply be held high, every cycle after the trigger is stored, including cycles where the flag is low. Gaps in the producer's valid signal therefore show up directly in the captured record.

After reset the buffer waits in an armed state. Capture starts on the hardware trigger input, or immediately when the software trigger input is pulsed. Samples are written to consecutive addresses until the buffer holds DEPTH entries. At that point writing stops and a done flag stays high until an arm pulse clears the buffer and re-arms it. A registered read port returns any stored entry, and a count output reports how many entries have been written.

The sample input follows valid/ready rules. `smp_wen` is the valid signal and `smp_rdy` is the ready signal. A sample is taken on any edge where both are high. The block never holds a producer back. A sample offered while `smp_rdy` is low is dropped, and the producer need not keep it stable.

Top module: `snap_capture`

## Requirements
- R1: After reset, `done` is 0, `count` is 0, `smp_rdy` is 0, and the block is armed and waiting for a trigger.
- R2: While armed and with no trigger present, enabled samples are not stored, and `count` stays at 0.
- R3: While armed, a high `hw_trig` starts capture. The sample offered in that same cycle is stored if `smp_wen` is high.
- R4: While armed, a high `sw_trig` starts capture in the same way as `hw_trig`, including the sample of that cycle.
- R5: During capture, each cycle with `smp_wen` high stores the entry {`smp_flag`, `smp_pwr`} at the next address, starting at address 0. The flag sits in bit PWR_W and the power word in bits PWR_W-1:0. Entries whose flag is 0 are stored like any other, and `count` rises by one per stored entry.
- R6: During capture, a cycle with `smp_wen` low stores nothing, and the write address does not advance.
- R7: On the edge that stores entry number DEPTH, `done` rises and `count` equals DEPTH. After that, `smp_rdy` stays low and offered samples are not stored.
- R8: A trigger that arrives after capture has started, or while `done` is high, has no effect. Capture does not restart and `count` is unchanged.
- R9: An arm pulse clears `count` and `done` and returns the block to the armed state. It takes priority over a trigger or a sample in the same cycle, and that sample is not stored.
- R10: `rd_word` shows the entry at the `rd_addr` value presented at the previous clock edge. The read latency is one cycle.
- R11: `smp_rdy` is high in exactly those cycles in which an offered sample would be stored. This means the block is capturing, or armed with a trigger present, with no arm pulse and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Clear the buffer and re-arm |
| hw_trig | input | 1 | Hardware trigger |
| sw_trig | input | 1 | Software (manual) trigger |
| smp_wen | input | 1 | Sample valid / write enable |
| smp_pwr | input | PWR_W | Unsigned power word |
| smp_flag | input | 1 | Data-valid flag recorded with the sample |
| smp_rdy | output | 1 | Sample would be stored this cycle |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_word | output | PWR_W+1 | Stored entry {flag, power}, one cycle after the address |
| done | output | 1 | Buffer full, capture finished |
| count | output | $clog2(DEPTH+1) | Number of entries written |

## Verification
`smp_rdy` is combinational, so the bench compares it with its own model shortly after it drives a cycle's inputs, before the clock edge. `count` and `done` change on the edge that takes a sample, and the bench checks them two time units after that edge. Read data appears on the edge after the address is set. The monitor therefore registers a read request at the edge and compares `rd_word` with the head of the expected-entry queue at the following falling edge.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2
  } snap_state_e;
endpackage

// File: rtl/snap_trig_fsm.sv
module snap_trig_fsm
  import snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic trig_any,
  input  logic wr_last,
  output logic cap_en,
  output logic done
);
  snap_state_e st;

  // A sample may be taken while running, or on the trigger cycle itself (R3, R4).
  always_comb begin
    cap_en = !arm && ((st == ST_RUN) || (st == ST_ARMED && trig_any));
  end

  assign done = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_ARMED;
    end else if (arm) begin
      st <= ST_ARMED;
    end else if (wr_last) begin
      st <= ST_DONE;
    end else if (st == ST_ARMED && trig_any) begin
      st <= ST_RUN;
    end
  end
endmodule

// File: rtl/snap_wr_ctrl.sv
module snap_wr_ctrl #(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       wr_go,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       wr_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;

  assign count   = cnt_q;
  assign wr_addr = cnt_q[AW-1:0];
  assign wr_last = wr_go && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      cnt_q <= '0;
    end else if (wr_go) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/snap_ram.sv
module snap_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int PWR_W = 31,
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       hw_trig,
  input  logic                       sw_trig,
  input  logic                       smp_wen,
  input  logic [PWR_W-1:0]           smp_pwr,
  input  logic                       smp_flag,
  output logic                       smp_rdy,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [PWR_W:0]             rd_word,
  output logic                       done,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int ENT_W = PWR_W + 1;
  localparam int AW    = $clog2(DEPTH);

  logic          cap_en;
  logic          wr_go;
  logic          wr_last;
  logic [AW-1:0] wr_addr;
  logic [ENT_W-1:0] entry;

  assign entry   = {smp_flag, smp_pwr};
  assign smp_rdy = cap_en;
  assign wr_go   = cap_en && smp_wen;

  snap_trig_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .trig_any (hw_trig | sw_trig),
    .wr_last  (wr_last),
    .cap_en   (cap_en),
    .done     (done)
  );

  snap_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .count   (count),
    .wr_last (wr_last)
  );

  snap_ram #(.W(ENT_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (entry),
    .raddr (rd_addr),
    .rdata (rd_word)
  );
endmodule

// File: rtl/snap_chk.sv
module snap_chk #(
  parameter int DEPTH = 1024
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       arm,
  input logic                       smp_wen,
  input logic                       smp_rdy,
  input logic                       done,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r7_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !smp_rdy);

  a_r7_full_done: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> done);

  a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (count == '0 && !done));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_rdy && smp_wen) |=> (count == CW'($past(count) + 1'b1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(smp_rdy && smp_wen) && !arm) |=> (count == $past(count)));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
endmodule

bind snap_capture snap_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .arm     (arm),
  .smp_wen (smp_wen),
  .smp_rdy (smp_rdy),
  .done    (done),
  .count   (count)
);

// File: tb/sim_snap_capture.sv
`timescale 1ns/1ps
module sim_snap_capture;
  localparam int PW    = 12;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n, arm, hw_trig, sw_trig, smp_wen, smp_flag, smp_rdy, done;
  logic [PW-1:0] smp_pwr;
  logic [AW-1:0] rd_addr;
  logic [PW:0]   rd_word;
  logic [CW-1:0] count;

  int checks = 0;
  int failures = 0;
  int mst = 0;   // 0 armed, 1 capturing, 2 done
  int mcnt = 0;
  logic [PW:0] exp_q[$];
  logic rd_go = 1'b0;
  logic rd_v = 1'b0;

  always #5 clk = ~clk;

  snap_capture #(.PWR_W(PW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hw_trig(hw_trig), .sw_trig(sw_trig),
    .smp_wen(smp_wen), .smp_pwr(smp_pwr), .smp_flag(smp_flag), .smp_rdy(smp_rdy),
    .rd_addr(rd_addr), .rd_word(rd_word), .done(done), .count(count)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes stored entries into the scoreboard.
  task automatic send(input string tag, input logic [PW-1:0] p, input logic f,
                      input logic w, input logic h, input logic s, input logic a);
    logic cap;
    @(negedge clk);
    smp_pwr = p; smp_flag = f; smp_wen = w; hw_trig = h; sw_trig = s; arm = a;
    cap = !a && ((mst == 0 && (h || s)) || mst == 1);
    #1 chk({"R11 ready ", tag}, 64'(smp_rdy), 64'(cap));
    @(posedge clk); #2;
    if (a) begin
      mst = 0; mcnt = 0; exp_q.delete();
    end else if (cap) begin
      if (w) begin exp_q.push_back({f, p}); mcnt++; end
      mst = (mcnt == DEPTH) ? 2 : 1;
    end
    chk({tag, " count"}, 64'(count), 64'(mcnt));
    chk({tag, " done"}, 64'(done), 64'(mst == 2));
  endtask

  task automatic idle();
    @(negedge clk);
    smp_pwr = '0; smp_flag = 0; smp_wen = 0; hw_trig = 0; sw_trig = 0; arm = 0;
  endtask

  task automatic readback(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_addr = AW'(i); rd_go = 1'b1;
    end
    @(negedge clk); rd_go = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: one edge after a read request, compare against the scoreboard head.
  always @(posedge clk) rd_v <= rd_go;
  always @(negedge clk) begin
    if (rd_v) begin
      if (exp_q.size() == 0) begin
        chk("R10 read with empty scoreboard", 64'(rd_word), 64'hFFFF_FFFF);
      end else begin
        chk("R10 R5 read entry", 64'(rd_word), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; arm = 0; hw_trig = 0; sw_trig = 0; smp_wen = 0;
    smp_pwr = '0; smp_flag = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 count", 64'(count), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 ready", 64'(smp_rdy), 64'd0);

    send("R2", 12'd11, 1, 1, 0, 0, 0);
    send("R2", 12'd12, 0, 1, 0, 0, 0);
    send("R2", 12'd13, 1, 1, 0, 0, 0);
    send("R3", 12'd100, 1, 1, 1, 0, 0);
    send("R5", 12'd101, 0, 1, 0, 0, 0);
    send("R6", 12'd102, 1, 0, 0, 0, 0);
    send("R8", 12'd103, 1, 1, 1, 0, 0);
    send("R8", 12'd104, 0, 1, 0, 1, 0);
    for (int i = 0; i < 12; i++) send("R5", 12'(200 + i), i[0], 1, 0, 0, 0);
    send("R7", 12'd999, 1, 1, 0, 0, 0);
    send("R8", 12'd998, 1, 1, 1, 1, 0);
    idle();
    readback(16);

    send("R9", 12'd5, 1, 1, 1, 0, 1);
    send("R9", 12'd6, 1, 1, 0, 0, 0);
    send("R4", 12'd7, 1, 1, 0, 1, 0);
    send("R4", 12'd8, 0, 1, 0, 0, 0);
    idle();
    readback(2);

    send("R9", 12'd9, 1, 1, 0, 0, 1);
    send("R9", 12'd10, 1, 1, 0, 0, 0);
    idle();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule